// File: doc/BRIEF.md
# AES-256 Key Schedule Engine

This block turns a 256-bit AES key into the fifteen 128-bit round keys that a 14-round AES-256 cipher consumes. It holds two fully separate expansion channels: one for the data key and one for the tweak key of an XTS-style storage cipher. Each channel can be loaded, and can run, without regard to the other. A channel takes its key on a single-cycle load strobe and builds one round key per cycle. It reports its progress through a busy level and a one-cycle done pulse. It then keeps the expanded schedule in registers, so every later cipher operation can reuse it without reloading.

The cipher data path reads the schedule through a per-channel read port. That port takes a 4-bit round index and returns the round key one cycle later. A load strobe that arrives while a channel is busy is dropped. The schedule being built is never disturbed mid-way.

Top module: `aks_pair`

## Requirements
- R1: When a channel's load input is high in a cycle where its busy output is low, the 256-bit key is sampled at that edge. From the next cycle busy is high and ready is low.
- R2: An accepted load keeps busy high for exactly 14 cycles. Done is high only in the 14th of them. In the cycle after done, busy is low and ready is high.
- R3: A load strobe seen while busy is high, including the cycle in which done is high, is ignored. It restarts nothing, and the schedule produced is that of the key already accepted.
- R4: Round key 0 equals key bits [255:128] and round key 1 equals key bits [127:0]. Round keys and words are big-endian: word 0 of a round key is bits [127:96], and byte 0 of a word is bits [31:24].
- R5: Words 8 to 59 follow w[i] = w[i-8] XOR t.
  - For i a multiple of 8, t is the S-box of each byte of w[i-1] rotated left by one byte, with Rcon XORed into bits [31:24]. Rcon is 0x01 for i=8 and doubles at each later multiple of 8.
  - For i = 4 mod 8, t is the S-box of each byte of w[i-1].
  - Otherwise t is w[i-1].
  - Round key k is words 4k to 4k+3.
- R6: A read index k from 0 to 14 on a channel's read port returns round key k on that channel's output one cycle later. Index 15 returns all zeros.
- R7: The data-key and tweak-key channels are independent. They may be loaded in the same cycle, and each then completes with its own correct schedule.
- R8: While the active-low synchronous reset is low, busy, done and ready go low and all stored round keys clear. Reads after reset return zero.
- R9: Once expansion finishes, the stored schedule stays unchanged until the next accepted load. Changes on the key input without a load strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dk_load | input | 1 | Data-key load strobe |
| dk_key | input | 256 | Data key, sampled with the strobe |
| dk_busy | output | 1 | Data-key expansion running |
| dk_done | output | 1 | Last cycle of data-key expansion |
| dk_ready | output | 1 | Data-key schedule stored and complete |
| dk_idx | input | 4 | Data-key round index to read |
| dk_rkey | output | 128 | Data-key round key, one cycle after index |
| tk_load | input | 1 | Tweak-key load strobe |
| tk_key | input | 256 | Tweak key, sampled with the strobe |
| tk_busy | output | 1 | Tweak-key expansion running |
| tk_done | output | 1 | Last cycle of tweak-key expansion |
| tk_ready | output | 1 | Tweak-key schedule stored and complete |
| tk_idx | input | 4 | Tweak-key round index to read |
| tk_rkey | output | 128 | Tweak-key round key, one cycle after index |

## Verification
The bench builds the block with its package defaults: a 256-bit key, 14 rounds and fifteen stored round keys. These are the only values for which the recurrence and the 14-cycle timing are defined. At these values every round index, including the unused index 15, is reachable from the read port. Every Rcon step up to 0x40 and both S-box word positions are therefore covered by a single expansion. The defaults also allow a known published AES-256 expansion vector to be compared word for word. Random keys on both channels, concurrent loads, and loads dropped mid-expansion and on the done cycle cover the handshake.

// File: rtl/aks_pkg.sv
// Shared sizes and GF(2^8) arithmetic for the AES-256 key schedule.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aks_pkg;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int RK_W       = 4 * WORD_W;
    localparam int KEY_W      = 2 * RK_W;
    localparam int NUM_ROUNDS = 14;
    localparam int NUM_RK     = NUM_ROUNDS + 1;
    localparam int IDX_W      = $clog2(NUM_RK + 1);

    // Field multiply by shift-and-add with modular reduction.
    function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a_in,
                                                 input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] p;
        a = a_in;
        p = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ a;
            a = {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    // Multiplicative inverse as a^254 (maps 0 to 0).
    function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] base;
        logic [BYTE_W-1:0] e;
        r    = 8'h01;
        base = a;
        e    = 8'd254;
        for (int i = 0; i < BYTE_W; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    // Forward S-box: inverse followed by the affine map.
    function automatic logic [BYTE_W-1:0] sbox_calc(input logic [BYTE_W-1:0] x);
        logic [BYTE_W-1:0] v;
        logic [BYTE_W-1:0] s;
        v = gf_inv(x);
        s = v ^ 8'h63;
        for (int k = 1; k <= 4; k++) s = s ^ ((v << k) | (v >> (BYTE_W - k)));
        return s;
    endfunction
endpackage

// File: rtl/aks_sbox.sv
// One S-box byte lane, computed rather than tabulated.
// Assumes a combinational path of two field exponentiation chains is acceptable.
module aks_sbox
    import aks_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    // Substitute one byte.
    always_comb dout = sbox_calc(din);
endmodule

// File: rtl/aks_round.sv
// Builds round key r from round keys r-2 and r-1 (the last word of r-1).
// Assumes 2 <= rnd <= 14; even rnd uses rotate plus Rcon, odd rnd uses S-box only.
module aks_round
    import aks_pkg::*;
(
    input  logic [RK_W-1:0]   old2,
    input  logic [WORD_W-1:0] last_w,
    input  logic [IDX_W-1:0]  rnd,
    output logic [RK_W-1:0]   nxt
);
    localparam int NWORD = RK_W / WORD_W;
    localparam int NBYTE = WORD_W / BYTE_W;

    logic [WORD_W-1:0] pre;
    logic [WORD_W-1:0] sub;
    logic [WORD_W-1:0] mix;
    logic [BYTE_W-1:0] rcon;
    logic [WORD_W-1:0] w [NWORD];

    // Rotate the input word only on even rounds.
    always_comb pre = rnd[0] ? last_w : {last_w[WORD_W-BYTE_W-1:0], last_w[WORD_W-1 -: BYTE_W]};

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        aks_sbox u_sb (.din(pre[b*BYTE_W +: BYTE_W]), .dout(sub[b*BYTE_W +: BYTE_W]));
    end

    // Round constant doubles every second round key.
    always_comb rcon = 8'h01 << (rnd[IDX_W-1:1] - 3'd1);

    // Chain the four words of the new round key.
    always_comb begin
        mix = sub ^ (rnd[0] ? '0 : {rcon, {(WORD_W-BYTE_W){1'b0}}});
        for (int j = 0; j < NWORD; j++) begin
            w[j] = old2[RK_W-1-j*WORD_W -: WORD_W] ^ ((j == 0) ? mix : w[(j == 0) ? 0 : j-1]);
            nxt[RK_W-1-j*WORD_W -: WORD_W] = w[j];
        end
    end
endmodule

// File: rtl/aks_core.sv
// One key-expansion channel: accept a key, generate one round key per
// cycle over 14 busy cycles, store all fifteen, serve a registered read port.
// Assumes load strobes during busy are to be dropped.
module aks_core
    import aks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [KEY_W-1:0] key,
    output logic             busy,
    output logic             done,
    output logic             ready,
    input  logic [IDX_W-1:0] idx,
    output logic [RK_W-1:0]  rkey
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ROUNDS);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(NUM_RK);

    logic [RK_W-1:0]  rk_mem [NUM_RK];
    logic [RK_W-1:0]  old2;
    logic [RK_W-1:0]  old1;
    logic [RK_W-1:0]  nxt;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] rnd;

    always_comb rnd  = cnt + 1'b1;
    always_comb done = busy && (cnt == LAST);

    aks_round u_round (.old2(old2), .last_w(old1[WORD_W-1:0]), .rnd(rnd), .nxt(nxt));

    // Load control, step counter and round-key storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            ready <= 1'b0;
            cnt   <= '0;
            old2  <= '0;
            old1  <= '0;
            for (int i = 0; i < NUM_RK; i++) rk_mem[i] <= '0;
        end else if (!busy) begin
            if (load) begin
                rk_mem[0] <= key[KEY_W-1:RK_W];
                rk_mem[1] <= key[RK_W-1:0];
                old2      <= key[KEY_W-1:RK_W];
                old1      <= key[RK_W-1:0];
                cnt       <= IDX_W'(1);
                busy      <= 1'b1;
                ready     <= 1'b0;
            end
        end else if (cnt == LAST) begin
            busy  <= 1'b0;
            ready <= 1'b1;
        end else begin
            rk_mem[rnd] <= nxt;
            old2        <= old1;
            old1        <= nxt;
            cnt         <= rnd;
        end
    end

    // Registered read port; out-of-range index reads zero.
    always_ff @(posedge clk) begin
        if (!rst_n) rkey <= '0;
        else        rkey <= (idx < TOP) ? rk_mem[idx] : '0;
    end
endmodule

// File: rtl/aks_pair.sv
// Two independent AES-256 key-schedule channels: data key and tweak key.
// Assumes both channels share one clock and one reset.
module aks_pair
    import aks_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dk_load,
    input  logic [KEY_W-1:0] dk_key,
    output logic             dk_busy,
    output logic             dk_done,
    output logic             dk_ready,
    input  logic [IDX_W-1:0] dk_idx,
    output logic [RK_W-1:0]  dk_rkey,
    input  logic             tk_load,
    input  logic [KEY_W-1:0] tk_key,
    output logic             tk_busy,
    output logic             tk_done,
    output logic             tk_ready,
    input  logic [IDX_W-1:0] tk_idx,
    output logic [RK_W-1:0]  tk_rkey
);
    aks_core u_data (
        .clk(clk), .rst_n(rst_n), .load(dk_load), .key(dk_key),
        .busy(dk_busy), .done(dk_done), .ready(dk_ready),
        .idx(dk_idx), .rkey(dk_rkey)
    );

    aks_core u_tweak (
        .clk(clk), .rst_n(rst_n), .load(tk_load), .key(tk_key),
        .busy(tk_busy), .done(tk_done), .ready(tk_ready),
        .idx(tk_idx), .rkey(tk_rkey)
    );
endmodule

// File: rtl/aks_chk.sv
// Handshake and read-port checker for one key-schedule channel.
// Assumes it is bound once per channel of aks_pair.
module aks_chk
    import aks_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic             busy,
    input logic             done,
    input logic             ready,
    input logic [IDX_W-1:0] idx,
    input logic [RK_W-1:0]  rkey
);
    logic [4:0] cyc;

    // Count busy cycles since the accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n)              cyc <= '0;
        else if (load && !busy)  cyc <= 5'd1;
        else if (busy)           cyc <= cyc + 5'd1;
    end

    assert_load_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (busy && !ready));
    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && cyc == 5'(NUM_ROUNDS)));
    assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && ready && !done));
    assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    assert_range_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == 4'd15) |=> (rkey == '0));
    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !ready && rkey == '0));
    assert_hold_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load && !$past(busy) && !$past(load) && $stable(idx)) |=> $stable(rkey));
endmodule

bind aks_pair aks_chk u_chk_d (
    .clk(clk), .rst_n(rst_n), .load(dk_load), .busy(dk_busy), .done(dk_done),
    .ready(dk_ready), .idx(dk_idx), .rkey(dk_rkey)
);

bind aks_pair aks_chk u_chk_t (
    .clk(clk), .rst_n(rst_n), .load(tk_load), .busy(tk_busy), .done(tk_done),
    .ready(tk_ready), .idx(tk_idx), .rkey(tk_rkey)
);

// File: tb/sim_aks_pair.sv
module sim_aks_pair;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dk_load = 1'b0, tk_load = 1'b0;
    logic [255:0] dk_key = '0, tk_key = '0;
    logic         dk_busy, dk_done, dk_ready, tk_busy, tk_done, tk_ready;
    logic [3:0]   dk_idx = '0, tk_idx = '0;
    logic [127:0] dk_rkey, tk_rkey;
    int checks = 0;
    int errors = 0;
    logic [127:0] exp_rk [15];

    always #10 clk = ~clk;

    aks_pair u0 (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
    end

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] m_sb(input logic [7:0] x);
        logic [7:0] v = 0;
        logic [7:0] o;
        logic [7:0] c = 8'h63;
        for (int y = 1; y < 256; y++) if (x != 0 && m_mul(x, 8'(y)) == 8'h01) v = 8'(y);
        for (int i = 0; i < 8; i++)
            o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8] ^ c[i];
        return o;
    endfunction

    function automatic logic [31:0] m_subw(input logic [31:0] w);
        return {m_sb(w[31:24]), m_sb(w[23:16]), m_sb(w[15:8]), m_sb(w[7:0])};
    endfunction

    task automatic ref_expand(input logic [255:0] key);
        logic [31:0] w [60];
        logic [31:0] t;
        logic [7:0] rc = 8'h01;
        for (int i = 0; i < 8; i++) w[i] = key[255-32*i -: 32];
        for (int i = 8; i < 60; i++) begin
            t = w[i-1];
            if (i % 8 == 0) begin
                t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
                rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
            end else if (i % 8 == 4) t = m_subw(t);
            w[i] = w[i-8] ^ t;
        end
        for (int k = 0; k < 15; k++) exp_rk[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
    endtask

    function automatic logic o_busy(input bit ch);  return ch ? tk_busy : dk_busy;   endfunction
    function automatic logic o_done(input bit ch);  return ch ? tk_done : dk_done;   endfunction
    function automatic logic o_ready(input bit ch); return ch ? tk_ready : dk_ready; endfunction

    task automatic set_load(input bit ch, input logic v, input logic [255:0] k);
        if (ch) begin tk_load = v; tk_key = k; end
        else    begin dk_load = v; dk_key = k; end
    endtask

    // Count busy cycles from the negedge after the accepted load until done.
    task automatic wait_done(input bit ch, output int c);
        c = 1;
        while (!o_done(ch) && c < 40) begin @(negedge clk); c++; end
    endtask

    task automatic run_one(input bit ch, input logic [255:0] k);
        int c;
        set_load(ch, 1'b1, k);
        @(negedge clk);
        set_load(ch, 1'b0, k);
        chk("R1 busy after load", 128'(o_busy(ch)), 128'd1);
        chk("R1 ready drops", 128'(o_ready(ch)), 128'd0);
        wait_done(ch, c);
        chk("R2 busy cycles", 128'(c), 128'd14);
        chk("R2 busy during done", 128'(o_busy(ch)), 128'd1);
        @(negedge clk);
        chk("R2 busy low after", 128'(o_busy(ch)), 128'd0);
        chk("R2 ready after", 128'(o_ready(ch)), 128'd1);
    endtask

    task automatic verify(input bit ch, input logic [255:0] k, input string tag);
        ref_expand(k);
        for (int r = 0; r < 15; r++) begin
            if (ch) tk_idx = 4'(r); else dk_idx = 4'(r);
            @(negedge clk);
            chk(r < 2 ? {tag, " R4 halves"} : {tag, " R5 round key"}, ch ? tk_rkey : dk_rkey, exp_rk[r]);
        end
    endtask

    initial begin
        logic [255:0] ka, kb, kc;
        int c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R8 reset busy", {dk_busy, tk_busy, dk_done, tk_done, dk_ready, tk_ready}, 128'd0);
        rst_n = 1'b1;
        dk_idx = 4'd5; tk_idx = 4'd0;
        @(negedge clk);
        chk("R8 cleared dk", dk_rkey, 128'd0);
        chk("R8 cleared tk", tk_rkey, 128'd0);

        // Published vector, data channel.
        ka = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
        run_one(1'b0, ka);
        verify(1'b0, ka, "R7 data");
        dk_idx = 4'd14;
        @(negedge clk);
        chk("R5 known round 14", dk_rkey, 128'h24fc79ccbf0979e9371ac23c6d68de36);
        dk_idx = 4'd15;
        @(negedge clk);
        chk("R6 index 15 zero", dk_rkey, 128'd0);
        chk("R7 tweak untouched", 128'(tk_ready), 128'd0);

        // Key input wiggles without load: schedule kept.
        dk_key = {8{$urandom()}};
        repeat (5) @(negedge clk);
        verify(1'b0, ka, "R9 hold");

        // Loads dropped mid-expansion and on the done cycle.
        kb = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        kc = ~kb;
        set_load(1'b0, 1'b1, kb);
        @(negedge clk);
        set_load(1'b0, 1'b0, kb);
        repeat (4) @(negedge clk);
        set_load(1'b0, 1'b1, kc);
        @(negedge clk);
        set_load(1'b0, 1'b0, kc);
        c = 6;
        while (!dk_done && c < 40) begin @(negedge clk); c++; end
        chk("R3 length unchanged", 128'(c), 128'd14);
        set_load(1'b0, 1'b1, kc);
        @(negedge clk);
        chk("R3 done-cycle load ignored", 128'(dk_busy), 128'd0);
        set_load(1'b0, 1'b0, kc);
        verify(1'b0, kb, "R3 first key kept");

        // Both channels loaded together.
        ka = {8{$urandom()}} ^ {$urandom(), 224'h0};
        kb = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        set_load(1'b0, 1'b1, ka);
        set_load(1'b1, 1'b1, kb);
        @(negedge clk);
        set_load(1'b0, 1'b0, ka);
        set_load(1'b1, 1'b0, kb);
        wait_done(1'b0, c);
        chk("R7 data length", 128'(c), 128'd14);
        chk("R7 tweak done together", 128'(tk_done), 128'd1);
        @(negedge clk);
        verify(1'b0, ka, "R7 concurrent data");
        verify(1'b1, kb, "R7 concurrent tweak");

        // Random keys on random channels.
        for (int n = 0; n < 6; n++) begin
            bit ch;
            ch = 1'($urandom());
            ka = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
            run_one(ch, ka);
            verify(ch, ka, "R5 random");
        end
        summary();
    end
endmodule